// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a 4-bit counter that is stepped by two separate strobe inputs rather than by a clock and a direction bit. A rising edge on the up strobe adds one and a rising edge on the down strobe takes one away. A parameter selects the sequence: decade (0 to 9) or full modulo-16 binary. A 4-bit preset can be loaded through an active-low load input, and an active-high clear forces the count to zero. Both clear and load act on the output at once and take priority over the strobes.

All inputs are sampled on one system clock. Strobe edges are found by comparing each strobe with its value from the previous clock. The active-low carry and borrow outputs copy their strobe while the counter sits at its terminal state. Several counters can therefore be chained by wiring one stage's carry and borrow to the next stage's up and down strobes.

Top module: `dual_strobe_counter`

## Requirements
- R1: While clear is low and load_n is high, a rising edge on up_strobe_i alone (sampled low on one clock, high on the next) increments the count by one, and count_o shows it one clock later.
- R2: Under the same conditions, a rising edge on down_strobe_i alone decrements the count by one.
- R3: Counting up from the terminal-up state (9 in decade mode, 15 in binary mode) gives 0, and counting down from 0 gives the terminal-up state.
- R4: While clear_i is high, count_o is 0 in the same cycle whatever load_n_i and the strobes do, and the count is 0 after clear_i falls.
- R5: While clear_i is low and load_n_i is low, count_o equals preset_i in the same cycle whatever the strobes do, and the count holds preset_i after load_n_i rises.
- R6: carry_n_o is low exactly when count_o equals the terminal-up state and up_strobe_i is low; otherwise it is high.
- R7: borrow_n_o is low exactly when count_o is 0 and down_strobe_i is low; otherwise it is high.
- R8: Rising edges on both strobes in the same clock leave the count unchanged.
- R9: If a strobe is low during and after a clear or a load, its next rising edge is counted.
- R10: In decade mode, a preset of 10 to 15 is loaded as given. Counting up from it adds one modulo 16 (15 goes to 0), and counting down from it subtracts one.
- R11: Two decade stages, with the second stage's up and down strobes driven by the first stage's carry_n_o and borrow_n_o, count 0 to 99 and back as a correct two-digit number.
- R12: A strobe held high counts once only; its rising edge is reported for a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock on which all inputs are sampled |
| clear_i | input | 1 | Active-high clear, highest priority |
| load_n_i | input | 1 | Active-low parallel load of preset_i |
| preset_i | input | 4 | Value to load |
| up_strobe_i | input | 1 | Count-up strobe, acts on its rising edge |
| down_strobe_i | input | 1 | Count-down strobe, acts on its rising edge |
| count_o | output | 4 | Current count, with clear and load applied at once |
| carry_n_o | output | 1 | Active-low carry, copies up_strobe_i at the terminal-up state |
| borrow_n_o | output | 1 | Active-low borrow, copies down_strobe_i at zero |

## Verification
A wrong stored count appears on count_o one clock after the strobe edge that caused it. The carry and borrow outputs follow count_o and the raw strobes without any register, so they show the same fault in the same cycle, at the next low phase of the strobe. A lost or duplicated edge record shows up as a missed or doubled step at the next strobe rise. In the chained pair the fault appears as a wrong tens digit at the next decade boundary. Because of this, every count value, wrap point and priority case is compared against the model on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int DSC_W = 4;
    typedef logic [DSC_W-1:0] dsc_count_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } dsc_step_e;

    typedef struct packed {
        dsc_count_t count;
    } dsc_state_t;
endpackage

// File: rtl/dsc_strobe_edge.sv
module dsc_strobe_edge #(
    parameter int NUM = 2
) (
    input  logic           clk_i,
    input  logic [NUM-1:0] strobe_i,
    output logic [NUM-1:0] rise_o
);
    logic [NUM-1:0] prev_d, prev_q;

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        always_comb begin
            prev_d[g] = strobe_i[g];
            rise_o[g] = ~prev_q[g] & strobe_i[g];
        end
    end

    always_ff @(posedge clk_i) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/dsc_step_logic.sv
module dsc_step_logic
    import dsc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  dsc_count_t count_i,
    input  dsc_step_e  step_i,
    output dsc_count_t count_o
);
    localparam dsc_count_t TERM_UP = DECADE ? dsc_count_t'(9) : {DSC_W{1'b1}};

    always_comb begin
        count_o = count_i;
        unique case (step_i)
            STEP_UP: begin
                if (count_i == TERM_UP) count_o = '0;
                else                    count_o = count_i + 1'b1;
            end
            STEP_DOWN: begin
                if (count_i == '0) count_o = TERM_UP;
                else               count_o = count_i - 1'b1;
            end
            default: count_o = count_i;
        endcase
    end
endmodule

// File: rtl/dsc_term_flags.sv
module dsc_term_flags
    import dsc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  dsc_count_t value_i,
    input  logic       up_strobe_i,
    input  logic       down_strobe_i,
    output logic       carry_n_o,
    output logic       borrow_n_o
);
    localparam dsc_count_t TERM_UP = DECADE ? dsc_count_t'(9) : {DSC_W{1'b1}};

    logic at_top, at_bottom;

    always_comb begin
        at_top     = (value_i == TERM_UP);
        at_bottom  = (value_i == '0);
        carry_n_o  = ~(at_top & ~up_strobe_i);
        borrow_n_o = ~(at_bottom & ~down_strobe_i);
    end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic       clk_i,
    input  logic       clear_i,
    input  logic       load_n_i,
    input  logic [3:0] preset_i,
    input  logic       up_strobe_i,
    input  logic       down_strobe_i,
    output logic [3:0] count_o,
    output logic       carry_n_o,
    output logic       borrow_n_o
);
    localparam dsc_count_t TERM_UP = DECADE ? dsc_count_t'(9) : {DSC_W{1'b1}};
    localparam int UP_IDX = 0;
    localparam int DN_IDX = 1;

    dsc_state_t state_d, state_q;
    logic [1:0] rise;
    dsc_step_e  step;
    dsc_count_t stepped;
    dsc_count_t shown;

    dsc_strobe_edge #(.NUM(2)) u_edge (
        .clk_i    (clk_i),
        .strobe_i ({down_strobe_i, up_strobe_i}),
        .rise_o   (rise)
    );

    always_comb begin
        unique case (rise)
            2'b01:   step = STEP_UP;
            2'b10:   step = STEP_DOWN;
            default: step = STEP_HOLD;
        endcase
    end

    dsc_step_logic #(.DECADE(DECADE)) u_step (
        .count_i (state_q.count),
        .step_i  (step),
        .count_o (stepped)
    );

    always_comb begin
        state_d = state_q;
        if (clear_i)        state_d.count = '0;
        else if (!load_n_i) state_d.count = preset_i;
        else                state_d.count = stepped;

        if (clear_i)        shown = '0;
        else if (!load_n_i) shown = preset_i;
        else                shown = state_q.count;
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign count_o = shown;

    dsc_term_flags #(.DECADE(DECADE)) u_flags (
        .value_i       (shown),
        .up_strobe_i   (up_strobe_i),
        .down_strobe_i (down_strobe_i),
        .carry_n_o     (carry_n_o),
        .borrow_n_o    (borrow_n_o)
    );

    a_r1_up_step: assert property (@(posedge clk_i) disable iff (clear_i)
        (load_n_i && rise == 2'b01 && state_q.count != TERM_UP)
        |=> state_q.count == dsc_count_t'($past(state_q.count) + 1'b1));

    a_r2_down_step: assert property (@(posedge clk_i) disable iff (clear_i)
        (load_n_i && rise == 2'b10 && state_q.count != '0)
        |=> state_q.count == dsc_count_t'($past(state_q.count) - 1'b1));

    a_r3_wrap_up: assert property (@(posedge clk_i) disable iff (clear_i)
        (load_n_i && rise[UP_IDX] && !rise[DN_IDX] && state_q.count == TERM_UP)
        |=> state_q.count == '0);

    a_r3_wrap_down: assert property (@(posedge clk_i) disable iff (clear_i)
        (load_n_i && rise[DN_IDX] && !rise[UP_IDX] && state_q.count == '0)
        |=> state_q.count == TERM_UP);

    a_r4_after_clear: assert property (@(posedge clk_i) disable iff (clear_i)
        $past(clear_i) |-> state_q.count == '0);

    a_r5_after_load: assert property (@(posedge clk_i) disable iff (clear_i)
        ($past(!load_n_i) && !$past(clear_i)) |-> state_q.count == $past(preset_i));

    a_r6_carry_low: assert property (@(posedge clk_i) disable iff (clear_i)
        !carry_n_o |-> (!up_strobe_i && count_o == TERM_UP));

    a_r7_borrow_low: assert property (@(posedge clk_i) disable iff (clear_i)
        !borrow_n_o |-> (!down_strobe_i && count_o == '0));

    a_r8_both_hold: assert property (@(posedge clk_i) disable iff (clear_i)
        (load_n_i && rise == 2'b11) |=> $stable(state_q.count));

    a_r12_single_rise: assert property (@(posedge clk_i) disable iff (clear_i)
        rise[UP_IDX] |=> !rise[UP_IDX]);
endmodule

// File: tb/dual_strobe_counter_tb.sv
module dual_strobe_counter_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       clr = 1'b1, ld_n = 1'b1, up = 1'b1, dn = 1'b1;
    logic [3:0] pre = 4'd0;
    logic [3:0] dec_q, bin_q;
    logic       dec_c, dec_b, bin_c, bin_b;

    logic       c_clr = 1'b1, c_up = 1'b1, c_dn = 1'b1;
    logic [3:0] lo_q, hi_q;
    logic       lo_c, lo_b, hi_c, hi_b;

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R4";
    bit    done = 1'b0;

    dual_strobe_counter #(.DECADE(1'b1)) u_dut (
        .clk_i(clk), .clear_i(clr), .load_n_i(ld_n), .preset_i(pre),
        .up_strobe_i(up), .down_strobe_i(dn),
        .count_o(dec_q), .carry_n_o(dec_c), .borrow_n_o(dec_b));

    dual_strobe_counter #(.DECADE(1'b0)) u_bin (
        .clk_i(clk), .clear_i(clr), .load_n_i(ld_n), .preset_i(pre),
        .up_strobe_i(up), .down_strobe_i(dn),
        .count_o(bin_q), .carry_n_o(bin_c), .borrow_n_o(bin_b));

    dual_strobe_counter #(.DECADE(1'b1)) u_lo (
        .clk_i(clk), .clear_i(c_clr), .load_n_i(1'b1), .preset_i(4'd0),
        .up_strobe_i(c_up), .down_strobe_i(c_dn),
        .count_o(lo_q), .carry_n_o(lo_c), .borrow_n_o(lo_b));

    dual_strobe_counter #(.DECADE(1'b1)) u_hi (
        .clk_i(clk), .clear_i(c_clr), .load_n_i(1'b1), .preset_i(4'd0),
        .up_strobe_i(lo_c), .down_strobe_i(lo_b),
        .count_o(hi_q), .carry_n_o(hi_c), .borrow_n_o(hi_b));

    // behavioural reference: integer counts plus last strobe samples
    int m_dec = 0, m_bin = 0;
    bit m_up_prev = 1'b1, m_dn_prev = 1'b1;

    function automatic int step_model(int c, bit decade, bit go_up, bit go_dn);
        int top;
        top = decade ? 9 : 15;
        if (go_up && !go_dn) return (c == top) ? 0 : (c + 1) % 16;
        if (go_dn && !go_up) return (c == 0) ? top : c - 1;
        return c;
    endfunction

    always @(posedge clk) begin
        bit ru, rd;
        ru = !m_up_prev && up;
        rd = !m_dn_prev && dn;
        if (clr) begin
            m_dec <= 0; m_bin <= 0;
        end else if (!ld_n) begin
            m_dec <= pre; m_bin <= pre;
        end else begin
            m_dec <= step_model(m_dec, 1'b1, ru, rd);
            m_bin <= step_model(m_bin, 1'b0, ru, rd);
        end
        m_up_prev <= up;
        m_dn_prev <= dn;
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int ed, eb;
        if (!done) begin
            ed = clr ? 0 : (!ld_n ? int'(pre) : m_dec);
            eb = clr ? 0 : (!ld_n ? int'(pre) : m_bin);
            check(cur_req, "decade count", dec_q, ed);
            check(cur_req, "binary count", bin_q, eb);
            check("R6", "decade carry", dec_c, (ed == 9 && !up) ? 0 : 1);
            check("R6", "binary carry", bin_c, (eb == 15 && !up) ? 0 : 1);
            check("R7", "decade borrow", dec_b, (ed == 0 && !dn) ? 0 : 1);
            check("R7", "binary borrow", bin_b, (eb == 0 && !dn) ? 0 : 1);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_up(int n);
        for (int i = 0; i < n; i++) begin
            up = 1'b0; tick(2);
            up = 1'b1; tick(2);
        end
    endtask

    task automatic pulse_dn(int n);
        for (int i = 0; i < n; i++) begin
            dn = 1'b0; tick(2);
            dn = 1'b1; tick(2);
        end
    endtask

    task automatic casc_up();
        c_up = 1'b0; tick(2);
        c_up = 1'b1; tick(2);
    endtask

    task automatic casc_dn();
        c_dn = 1'b0; tick(2);
        c_dn = 1'b1; tick(2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R4: clear wins over load and strobes
        tick(2);
        cur_req = "R4";
        ld_n = 1'b0; pre = 4'd5; up = 1'b0; tick(2);
        up = 1'b1; tick(2);
        ld_n = 1'b1; clr = 1'b0; tick(2);

        // R1, R3 up direction; R12 held strobe counts once
        cur_req = "R1";
        pulse_up(5);
        cur_req = "R3";
        pulse_up(12);
        cur_req = "R12";
        tick(10);

        // R2, R3 down direction
        cur_req = "R2";
        pulse_dn(3);
        cur_req = "R3";
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        pulse_dn(3);

        // R8: both strobes rise together
        cur_req = "R8";
        up = 1'b0; dn = 1'b0; tick(2);
        up = 1'b1; dn = 1'b1; tick(3);

        // R5: load while strobes move
        cur_req = "R5";
        ld_n = 1'b0; pre = 4'd7; up = 1'b0; tick(1);
        up = 1'b1; tick(1); dn = 1'b0; tick(1);
        ld_n = 1'b1; tick(1); dn = 1'b1; tick(2);

        // R9: strobe low across clear and across load
        cur_req = "R9";
        up = 1'b0; clr = 1'b1; tick(2); clr = 1'b0; tick(2);
        up = 1'b1; tick(2);
        dn = 1'b0; pre = 4'd4; ld_n = 1'b0; tick(2); ld_n = 1'b1; tick(2);
        dn = 1'b1; tick(2);

        // R10: decade mode with out-of-range preset
        cur_req = "R10";
        pre = 4'd12; ld_n = 1'b0; tick(1); ld_n = 1'b1; tick(1);
        pulse_up(5);
        pre = 4'd12; ld_n = 1'b0; tick(1); ld_n = 1'b1; tick(1);
        pulse_dn(4);

        // R11: two chained decade stages
        cur_req = "R11";
        tick(1); c_clr = 1'b0; tick(2);
        check("R11", "cascade start", hi_q * 10 + lo_q, 0);
        for (int k = 1; k <= 100; k++) begin
            casc_up();
            check("R11", "cascade up", hi_q * 10 + lo_q, k % 100);
        end
        for (int k = 1; k <= 12; k++) begin
            casc_dn();
            check("R11", "cascade down", hi_q * 10 + lo_q, (100 - k) % 100);
        end

        tick(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule